// File: doc/BRIEF.md
# NAND Flash Page-Read Sequencer

This block is the bus master for an 8-bit asynchronous NAND flash device. It generates every control strobe itself: an active-low chip select, the command and address latch strobes, active-low write and read strobes, and the pad-side controls of a bidirectional data bus. It also watches the device's ready/busy line. The sequencer has two jobs. It can reset the device at start-up, and it can read a run of bytes from one page. The bytes it reads go out on a single-cycle valid/data stream.

A page read takes a block number, a page number, a start byte and a byte count, plus a geometry select for 512-byte or 2048-byte pages. The block first checks the block and page numbers. It then sends a read command, chosen according to whether the start byte lies in the main area or in the spare area. Next come four address cycles whose packing depends on the geometry, and, for large pages only, a confirm command. After a settling delay the block polls ready/busy, with a timeout. It then reads the bytes one by one, turning the data bus around for each. Every strobe phase lasts a parameterised number of clock cycles.

Top module: `nand_page_reader`

## Requirements
- R1: Out of reset and while not busy, the outputs hold `nand_ce_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1 and `nand_dq_oe`=1.
- R2: A bus write cycle raises exactly one of `nand_cle` (command) or `nand_ale` (address). It drives the byte while `nand_we_n` is low and keeps both the byte and the latch strobe steady across the rising edge of `nand_we_n`. Both latch strobes are low between cycles.
- R3: `init_req` asserts chip select, writes the RESET_CMD byte (default 0xFF) as a single command cycle, releases chip select and then waits for `nand_rb`=1. It finishes with a `done` pulse, and `err_timeout`=1 if ready never appeared within TIMEOUT polling cycles.
- R4: The first command of a read is READ_CMD (default 0x00) when the start byte is below the page size (512 when `rd_large`=0, 2048 when `rd_large`=1). Otherwise the first command is 0x50.
- R5: With `rd_large`=0, form A = block<<14 | page<<9 | (start byte mod 512). The block then writes four address bytes in this order: A[7:0], A[16:9], A[24:17] and A[25] (upper seven bits zero). No further command follows.
- R6: With `rd_large`=1, form A = block<<22 | page<<16 | start byte. The block then writes four address bytes in this order: A[7:0], A[11:8] (upper nibble zero), A[23:16] and A[31:24]. A 0x30 command cycle follows them.
- R7: After the address phase and a settling delay, the block polls `nand_rb`. If ready is still low after TIMEOUT polling cycles, no data byte is read, chip select is released, and `done` comes with `err_timeout`=1.
- R8: The block reads `rd_count` bytes. For each one it drives `nand_dq_oe`=0 and `nand_re_n`=0, then samples `nand_dq_i` at the end of the low phase. Each sampled byte appears on `out_data` with a one-cycle `out_valid`, in read order.
- R9: A read whose block is not below NUM_BLOCKS, or whose page is not below 32 (small) or 64 (large), ends with `done` and `err_addr`=1. Chip select stays high throughout and no strobe toggles.
- R10: Chip select stays low from before the first command of a read until after its last byte. It is released before `done`.
- R11: `done` is a single-cycle pulse, exactly one per accepted request. `busy` is high from acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start the device reset sequence (sampled when idle, wins over a read) |
| rd_req | input | 1 | Start a page read (sampled when idle) |
| rd_large | input | 1 | Geometry select: 0 = 512-byte pages, 1 = 2048-byte pages |
| rd_block | input | 12 | Block number |
| rd_page | input | 6 | Page within block |
| rd_col | input | 12 | Start byte within the page (spare area above page size) |
| rd_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Ready wait expired (valid with done) |
| err_addr | output | 1 | Request rejected for block/page range (valid with done) |
| out_valid | output | 1 | One-cycle strobe for a read byte |
| out_data | output | 8 | Read byte |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input value |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The assertions assume that the request inputs are only examined while `busy` is low and that `nand_rb` behaves like a real device. They also assume that `nand_dq_i` is driven by the device while the read strobe is low. The stimulus issues each request as a one-cycle pulse from idle and then waits for `done` before starting another. A behavioural flash model drops ready for a fixed time after every latched command and presents a known byte pattern, stepped on each rising read strobe. For the timeout cases it holds ready low permanently.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  localparam int BLK_W = 12;
  localparam int PG_W  = 6;
  localparam int COL_W = 12;
  localparam int SLOTS = 6;

  localparam logic [7:0] SPARE_RD_CMD = 8'h50;
  localparam logic [7:0] CONFIRM_CMD  = 8'h30;

  typedef enum logic [3:0] {
    S_IDLE, S_CE, S_WLO, S_WHI, S_GAP, S_SETTLE, S_POLL,
    S_RLO, S_RHI, S_RTURN, S_REL, S_DONE
  } seq_state_t;

endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
  import nand_rd_pkg::*;
#(
  parameter logic [7:0] READ_CMD = 8'h00
) (
  input  logic                        large_pg,
  input  logic [BLK_W-1:0]            block,
  input  logic [PG_W-1:0]             page,
  input  logic [COL_W-1:0]            col,
  output logic [SLOTS-1:0][7:0]       slot_byte
);
  localparam int SMALL_BYTES = 512;
  localparam int LARGE_BYTES = 2048;

  logic in_spare;

  always_comb begin
    in_spare = large_pg ? (int'(col) >= LARGE_BYTES) : (int'(col) >= SMALL_BYTES);
    slot_byte[0] = in_spare ? SPARE_RD_CMD : READ_CMD;
    if (large_pg) begin
      // packed: block at 22, page at 16, column at 0
      slot_byte[1] = col[7:0];
      slot_byte[2] = {4'h0, col[11:8]};
      slot_byte[3] = {block[1:0], page[5:0]};
      slot_byte[4] = block[9:2];
      slot_byte[5] = CONFIRM_CMD;
    end else begin
      // packed: block at 14, page at 9, column at 0; bit 8 never sent
      slot_byte[1] = col[7:0];
      slot_byte[2] = {block[2:0], page[4:0]};
      slot_byte[3] = block[10:3];
      slot_byte[4] = {7'h00, block[11]};
      slot_byte[5] = 8'h00;
    end
  end
endmodule

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [TW-1:0] count
);
  logic [TW-1:0] count_d;
  logic          count_en;

  always_comb begin
    count_en = restart || (count != {TW{1'b1}});
    count_d  = restart ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int         T_PH       = 4,
  parameter int         SETTLE     = 8,
  parameter int         TIMEOUT    = 100000,
  parameter int         NUM_BLOCKS = 1024,
  parameter int         CNT_W      = 12,
  parameter logic [7:0] READ_CMD   = 8'h00,
  parameter logic [7:0] RESET_CMD  = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             rd_req,
  input  logic             rd_large,
  input  logic [BLK_W-1:0] rd_block,
  input  logic [PG_W-1:0]  rd_page,
  input  logic [COL_W-1:0] rd_col,
  input  logic [CNT_W-1:0] rd_count,
  output logic             busy,
  output logic             done,
  output logic             err_timeout,
  output logic             err_addr,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb
);
  localparam int TW        = $clog2(TIMEOUT + T_PH + SETTLE + 2);
  localparam int PG_SMALL  = 32;
  localparam int PG_LARGE  = 64;
  localparam int LAST_SM   = 4;
  localparam int LAST_LG   = 5;

  seq_state_t state_q, state_d;
  logic [2:0]       slot_q, slot_d;
  logic             init_q, large_q;
  logic [BLK_W-1:0] blk_q;
  logic [PG_W-1:0]  pg_q;
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] rem_q;
  logic             err_to_q, err_ad_q;
  logic             vld_q;
  logic [7:0]       dat_q;

  logic [TW-1:0]          tmr;
  logic [SLOTS-1:0][7:0]  slot_byte;
  logic                   ph_end, st_end, to_end;
  logic                   acc_init, acc_rd, req_ok;
  logic [2:0]             last_slot;
  logic                   slot_is_cmd;
  logic                   write_ph, txn_ce;

  nand_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(state_d != state_q), .count(tmr)
  );

  nand_addr_gen #(.READ_CMD(READ_CMD)) u_addr (
    .large_pg(large_q), .block(blk_q), .page(pg_q), .col(col_q),
    .slot_byte(slot_byte)
  );

  always_comb begin
    ph_end    = (tmr == TW'(T_PH - 1));
    st_end    = (tmr == TW'(SETTLE - 1));
    to_end    = (tmr == TW'(TIMEOUT - 1));
    acc_init  = (state_q == S_IDLE) && init_req;
    acc_rd    = (state_q == S_IDLE) && !init_req && rd_req;
    req_ok    = (int'(rd_block) < NUM_BLOCKS) &&
                (int'(rd_page) < (rd_large ? PG_LARGE : PG_SMALL));
    last_slot = init_q ? 3'd0 : (large_q ? 3'(LAST_LG) : 3'(LAST_SM));
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    unique case (state_q)
      S_IDLE:   if (acc_init || (acc_rd && req_ok)) state_d = S_CE;
                else if (acc_rd) state_d = S_DONE;
      S_CE:     if (ph_end) begin state_d = S_WLO; slot_d = '0; end
      S_WLO:    if (ph_end) state_d = S_WHI;
      S_WHI:    if (ph_end) state_d = S_GAP;
      S_GAP:    if (ph_end) begin
                  if (slot_q == last_slot) state_d = S_SETTLE;
                  else begin state_d = S_WLO; slot_d = slot_q + 3'd1; end
                end
      S_SETTLE: if (st_end) state_d = S_POLL;
      S_POLL:   if (nand_rb) begin
                  if (init_q)           state_d = S_DONE;
                  else if (rem_q == '0) state_d = S_REL;
                  else                  state_d = S_RLO;
                end else if (to_end) begin
                  state_d = init_q ? S_DONE : S_REL;
                end
      S_RLO:    if (ph_end) state_d = S_RHI;
      S_RHI:    if (ph_end) state_d = S_RTURN;
      S_RTURN:  if (ph_end) state_d = (rem_q == CNT_W'(1)) ? S_REL : S_RLO;
      S_REL:    if (ph_end) state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      slot_q   <= '0;
      init_q   <= 1'b0;
      large_q  <= 1'b0;
      blk_q    <= '0;
      pg_q     <= '0;
      col_q    <= '0;
      rem_q    <= '0;
      err_to_q <= 1'b0;
      err_ad_q <= 1'b0;
      vld_q    <= 1'b0;
      dat_q    <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      vld_q   <= (state_q == S_RLO) && ph_end;
      if ((state_q == S_RLO) && ph_end) dat_q <= nand_dq_i;
      if (acc_init || acc_rd) begin
        init_q   <= acc_init;
        err_to_q <= 1'b0;
        err_ad_q <= acc_rd && !req_ok;
      end
      if (acc_rd) begin
        large_q <= rd_large;
        blk_q   <= rd_block;
        pg_q    <= rd_page;
        col_q   <= rd_col;
        rem_q   <= rd_count;
      end
      if ((state_q == S_RTURN) && ph_end) rem_q <= rem_q - CNT_W'(1);
      if ((state_q == S_POLL) && !nand_rb && to_end) err_to_q <= 1'b1;
    end
  end

  // output decode
  always_comb begin
    write_ph    = (state_q == S_WLO) || (state_q == S_WHI);
    slot_is_cmd = (slot_q == 3'd0) || (slot_q == 3'(LAST_LG));
    txn_ce      = (state_q == S_SETTLE) || (state_q == S_POLL) ||
                  (state_q == S_RLO) || (state_q == S_RHI) || (state_q == S_RTURN);
    nand_ce_n   = !((state_q == S_CE) || write_ph || (state_q == S_GAP) ||
                    (!init_q && txn_ce));
    nand_cle    = write_ph && slot_is_cmd;
    nand_ale    = write_ph && !slot_is_cmd;
    nand_we_n   = (state_q != S_WLO);
    nand_re_n   = (state_q != S_RLO);
    nand_dq_oe  = !((state_q == S_RLO) || (state_q == S_RHI));
    if (write_ph || (state_q == S_GAP))
      nand_dq_o = init_q ? RESET_CMD : slot_byte[slot_q];
    else
      nand_dq_o = 8'h00;
    busy        = (state_q != S_IDLE);
    done        = (state_q == S_DONE);
    err_timeout = err_to_q;
    err_addr    = err_ad_q;
    out_valid   = vld_q;
    out_data    = dat_q;
  end
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err_addr,
  input logic       out_valid,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_dq_o,
  input logic       nand_dq_oe
);
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_ce_n && !nand_cle && !nand_ale && nand_we_n && nand_re_n && nand_dq_oe));

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r2_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($stable(nand_dq_o) && (nand_cle || nand_ale)));

  a_r8_bus_turned: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_dq_oe && !nand_ce_n));

  a_r10_valid_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy && !nand_ce_n));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_addr) |-> (nand_ce_n && $past(nand_ce_n) && nand_we_n));
endmodule

bind nand_page_reader nand_page_reader_chk i_chk (.*);

// File: tb/test_nand_page_reader.sv
module test_nand_page_reader;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 40;
  localparam int TMO        = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, rd_req = 1'b0, rd_large = 1'b0;
  logic [11:0] rd_block = '0;
  logic [5:0]  rd_page = '0;
  logic [11:0] rd_col = '0;
  logic [11:0] rd_count = '0;
  logic busy, done, err_timeout, err_addr, out_valid;
  logic [7:0] out_data;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic nand_rb;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_page_reader #(.T_PH(4), .SETTLE(8), .TIMEOUT(TMO), .NUM_BLOCKS(1024),
                     .CNT_W(12), .READ_CMD(8'h00), .RESET_CMD(8'hFF)) i_nand_page_reader (
    .clk, .rst_n, .init_req, .rd_req, .rd_large, .rd_block, .rd_page, .rd_col,
    .rd_count, .busy, .done, .err_timeout, .err_addr, .out_valid, .out_data,
    .nand_ce_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n, .nand_dq_o,
    .nand_dq_oe, .nand_dq_i, .nand_rb);

  // flash model and monitors
  logic [7:0] log_b [0:15];
  logic       log_c [0:15];
  logic       log_a [0:15];
  int  log_n = 0, ce_bad = 0, busy_cnt = 0, idx = 0;
  logic stuck = 1'b0, we_prev = 1'b1, re_prev = 1'b1, done_prev = 1'b0;
  logic [7:0] cap [0:31];
  int  cap_n = 0, done_n = 0, done_dbl = 0, valid_ce_bad = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  assign nand_rb   = !stuck && (busy_cnt == 0);
  assign nand_dq_i = pat(idx);

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (!we_prev && nand_we_n) begin
      if (log_n < 16) begin
        log_b[log_n] <= nand_dq_o;
        log_c[log_n] <= nand_cle;
        log_a[log_n] <= nand_ale;
      end
      log_n <= log_n + 1;
      if (nand_ce_n) ce_bad <= ce_bad + 1;
      if (nand_cle) begin busy_cnt <= BUSY_CYC; idx <= 0; end
    end
    if (!re_prev && nand_re_n) idx <= idx + 1;
    if (out_valid) begin
      if (cap_n < 32) cap[cap_n] <= out_data;
      cap_n <= cap_n + 1;
      if (nand_ce_n) valid_ce_bad <= valid_ce_bad + 1;
    end
    if (done) done_n <= done_n + 1;
    if (done && done_prev) done_dbl <= done_dbl + 1;
    we_prev   <= nand_we_n;
    re_prev   <= nand_re_n;
    done_prev <= done;
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    log_n = 0; ce_bad = 0; cap_n = 0; done_n = 0; done_dbl = 0; valid_ce_bad = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue_read(bit lg, int blk, int pg, int col, int cnt);
    clear_logs();
    rd_large = lg; rd_block = 12'(blk); rd_page = 6'(pg);
    rd_col = 12'(col); rd_count = 12'(cnt); rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R11 busy after accept", int'(busy), 1);
    wait_done();
  endtask

  task automatic check_data(int cnt);
    chk("R8 byte count", cap_n, cnt);
    for (int i = 0; i < cnt && i < 32; i++) chk("R8 read byte", int'(cap[i]), int'(pat(i)));
    chk("R10 valid under chip select", valid_ce_bad, 0);
    chk("R10 released at end", int'(nand_ce_n), 1);
    chk("R10 writes under chip select", ce_bad, 0);
    chk("R11 single done", done_n, 1);
    chk("R11 done one cycle", done_dbl, 0);
    chk("R11 idle after done", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1 ce_n", int'(nand_ce_n), 1);
    chk("R1 cle", int'(nand_cle), 0);
    chk("R1 ale", int'(nand_ale), 0);
    chk("R1 we_n", int'(nand_we_n), 1);
    chk("R1 re_n", int'(nand_re_n), 1);
    chk("R1 dq_oe", int'(nand_dq_oe), 1);
    chk("R1 busy", int'(busy), 0);
  endtask

  task automatic t_init(bit hang);
    clear_logs();
    stuck = hang;
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    wait_done();
    chk("R3 one cycle written", log_n, 1);
    chk("R3 reset byte", int'(log_b[0]), 8'hFF);
    chk("R3 as command", int'(log_c[0]), 1);
    chk("R3 timeout flag", int'(err_timeout), int'(hang));
    chk("R3 chip select released", int'(nand_ce_n), 1);
    chk("R11 init done", done_n, 1);
    stuck = 1'b0;
  endtask

  task automatic t_small(int blk, int pg, int col, int cnt);
    logic [31:0] a;
    a = (32'(blk) << 14) | (32'(pg) << 9) | 32'(col % 512);
    issue_read(1'b0, blk, pg, col, cnt);
    chk("R5 cycle count", log_n, 5);
    chk("R4 read command", int'(log_b[0]), (col >= 512) ? 8'h50 : 8'h00);
    chk("R2 command strobe", int'({log_c[0], log_a[0]}), 2);
    chk("R5 addr byte 1", int'(log_b[1]), int'(a[7:0]));
    chk("R5 addr byte 2", int'(log_b[2]), int'((a >> 9) & 32'hFF));
    chk("R5 addr byte 3", int'(log_b[3]), int'((a >> 17) & 32'hFF));
    chk("R5 addr byte 4", int'(log_b[4]), int'((a >> 25) & 32'h1));
    for (int i = 1; i < 5; i++) chk("R2 address strobe", int'({log_c[i], log_a[i]}), 1);
    chk("R7 no timeout", int'(err_timeout), 0);
    check_data(cnt);
  endtask

  task automatic t_large(int blk, int pg, int col, int cnt);
    logic [31:0] a;
    a = (32'(blk) << 22) | (32'(pg) << 16) | 32'(col);
    issue_read(1'b1, blk, pg, col, cnt);
    chk("R6 cycle count", log_n, 6);
    chk("R4 read command", int'(log_b[0]), (col >= 2048) ? 8'h50 : 8'h00);
    chk("R6 addr byte 1", int'(log_b[1]), int'(a & 32'hFF));
    chk("R6 addr byte 2", int'(log_b[2]), int'((a >> 8) & 32'h0F));
    chk("R6 addr byte 3", int'(log_b[3]), int'((a >> 16) & 32'hFF));
    chk("R6 addr byte 4", int'(log_b[4]), int'((a >> 24) & 32'hFF));
    chk("R6 confirm byte", int'(log_b[5]), 8'h30);
    chk("R6 confirm as command", int'({log_c[5], log_a[5]}), 2);
    for (int i = 1; i < 5; i++) chk("R2 address strobe", int'({log_c[i], log_a[i]}), 1);
    check_data(cnt);
  endtask

  task automatic t_read_timeout();
    stuck = 1'b1;
    issue_read(1'b1, 3, 2, 0, 4);
    chk("R7 timeout flag", int'(err_timeout), 1);
    chk("R7 no data read", cap_n, 0);
    chk("R7 chip select released", int'(nand_ce_n), 1);
    chk("R7 single done", done_n, 1);
    stuck = 1'b0;
  endtask

  task automatic t_addr_err(bit lg, int blk, int pg);
    issue_read(lg, blk, pg, 0, 4);
    chk("R9 address error", int'(err_addr), 1);
    chk("R9 no bus cycles", log_n, 0);
    chk("R9 no data", cap_n, 0);
    chk("R9 done pulse", done_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_init(1'b0);
    t_init(1'b1);
    t_small(709, 19, 10, 6);
    t_small(1023, 31, 496, 3);
    t_small(5, 1, 515, 4);
    t_large(709, 45, 1234, 5);
    t_large(1023, 63, 2060, 3);
    t_read_timeout();
    t_addr_err(1'b0, 1024, 0);
    t_addr_err(1'b0, 4, 32);
    t_large(2, 40, 0, 1);
    chk("R9 cleared on next request", int'(err_addr), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule